// File: doc/BRIEF.md
# Clock-stop-reset elastic FIFO

This block moves 10-bit words from a parallel bus clock domain (the write side) into an internal link clock domain (the read side) through a small dual-clock memory. The pointers cross between domains in Gray code through synchroniser chains. The block also has a built-in way to resynchronise. A monitor runs on a free-running reference clock and watches the bus clock. Whenever the bus clock stops toggling, at either level, both sides of the FIFO are forced into reset. A user can therefore realign the buffer at any moment, for example while the clock source is being switched, just by parking the bus clock.

Once the monitor sees the bus clock toggling steadily again, it lets go of the reset. Each side leaves reset in step with its own clock. The write pointer starts half the depth ahead of the read pointer, so the buffer begins half full and can absorb equal drift in both directions. A write to a full buffer and a read from an empty one are both dropped. Each raises a flag that stays set until the next clock-stop reset.

Top module: `clkstop_elastic_fifo`

## Requirements
- R1: After the reference reset is released, and until the bus clock has been seen toggling, `wr_held` and `rd_held` are 1, `wr_overflow` and `rd_underflow` are 0, and `rd_data` is 0.
- R2: When `wr_clk` stays static, either high or low, for STOP_CYC (default 16) reference cycles, both `wr_held` and `rd_held` go to 1 within a few further reference cycles and stay 1 while the clock is static.
- R3: The hold is released only after RUN_EDGES (default 4) bus-clock toggles are seen with no silent gap of STOP_CYC reference cycles. Two rising edges after a restart are not enough. Each side then drops its hold on its own clock, SYNC (default 2) edges later.
- R4: Right after release, with no writes, exactly DEPTH/2 reads are accepted without underflow. With no reads, exactly DEPTH/2 writes are accepted without overflow.
- R5: Under concurrent traffic on both clocks, the accepted words come out in the order they were written and with the same values, after the DEPTH/2 words that were pre-filled at release.
- R6: A write while the buffer is full stores nothing and sets `wr_overflow`, which stays 1 until the next hold.
- R7: A read while the buffer is empty leaves `rd_data` unchanged and sets `rd_underflow`, which stays 1 until the next hold.
- R8: Stopping the bus clock at any point clears both sticky flags and restores the half-depth pointer spacing on the next release.
- R9: An accepted read presents its word on `rd_data` right after the `rd_clk` rising edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for the activity monitor |
| ref_rst_n | input | 1 | Active-low reset of the reference domain |
| wr_clk | input | 1 | Bus clock; stopping it resets the FIFO |
| wr_en | input | 1 | Write request, sampled on `wr_clk` |
| wr_data | input | WIDTH (10) | Word to write |
| wr_held | output | 1 | Write side is held in reset |
| wr_overflow | output | 1 | Sticky: a write hit a full buffer |
| rd_clk | input | 1 | Internal link clock |
| rd_en | input | 1 | Read request, sampled on `rd_clk` |
| rd_data | output | WIDTH (10) | Last word read |
| rd_held | output | 1 | Read side is held in reset |
| rd_underflow | output | 1 | Sticky: a read hit an empty buffer |

## Verification
Read data is due one `rd_clk` edge after the edge that accepts it. The bench drives requests on falling edges and samples on the next falling edge, or one nanosecond after the accepting rising edge for the latency check. The hold is due roughly STOP_CYC plus three reference cycles after the clock parks, so the bench waits forty reference cycles before sampling it. Release needs four observed toggles plus the synchronisers, so the bench samples two bus edges after a restart to confirm the hold is still present, then polls with a bounded timeout. Pointer changes take up to about four words' worth of time to cross domains, so the random traffic keeps the modelled fill level at least six entries away from empty and from full. Every accept or drop decision is then certain.

// File: rtl/clkstop_fifo_pkg.sv
package clkstop_fifo_pkg;

    // Activity monitor verdict on the bus clock
    typedef enum logic {
        MON_STOPPED = 1'b0,
        MON_RUNNING = 1'b1
    } mon_state_e;

    localparam int unsigned DEF_DEPTH     = 8;
    localparam int unsigned DEF_WIDTH     = 10;
    localparam int unsigned DEF_STOP_CYC  = 16;
    localparam int unsigned DEF_RUN_EDGES = 4;
    localparam int unsigned DEF_SYNC      = 2;

endpackage

// File: rtl/clk_activity_mon.sv
module clk_activity_mon
    import clkstop_fifo_pkg::*;
#(
    parameter int unsigned STOP_CYC  = DEF_STOP_CYC,
    parameter int unsigned RUN_EDGES = DEF_RUN_EDGES,
    parameter int unsigned SYNC      = DEF_SYNC
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic mon_clk,
    output logic clk_stopped
);
    localparam int unsigned IW = $clog2(STOP_CYC + 1);
    localparam int unsigned EW = $clog2(RUN_EDGES + 1);

    // Divide-by-two flop in the watched domain; its level changes are what the reference side sees
    logic tog_q;
    always_ff @(posedge mon_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) tog_q <= 1'b0;
        else            tog_q <= ~tog_q;
    end

    typedef struct packed {
        logic [SYNC-1:0] sync;
        logic            last;
        mon_state_e      mode;
        logic [IW-1:0]   idle;
        logic [EW-1:0]   edges;
    } mon_t;

    mon_t mon_d, mon_q;
    logic seen_edge;

    always_comb begin
        mon_d      = mon_q;
        mon_d.sync = {mon_q.sync[SYNC-2:0], tog_q};
        mon_d.last = mon_q.sync[SYNC-1];
        seen_edge  = mon_q.sync[SYNC-1] ^ mon_q.last;

        if (seen_edge)                        mon_d.idle = '0;
        else if (mon_q.idle != IW'(STOP_CYC)) mon_d.idle = mon_q.idle + 1'b1;

        case (mon_q.mode)
            MON_RUNNING: begin
                if (mon_d.idle == IW'(STOP_CYC)) begin
                    mon_d.mode  = MON_STOPPED;
                    mon_d.edges = '0;
                end
            end
            default: begin
                if (mon_d.idle == IW'(STOP_CYC)) begin
                    mon_d.edges = '0;
                end else if (seen_edge) begin
                    if (mon_q.edges == EW'(RUN_EDGES - 1)) begin
                        mon_d.mode  = MON_RUNNING;
                        mon_d.edges = '0;
                    end else begin
                        mon_d.edges = mon_q.edges + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) mon_q <= '0;
        else            mon_q <= mon_d;
    end

    assign clk_stopped = (mon_q.mode == MON_STOPPED);

    AST_STOP_ON_SILENCE: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (!clk_stopped && !seen_edge && mon_q.idle == IW'(STOP_CYC - 1)) |=> clk_stopped)
        else $error("monitor missed a silent bus clock"); // R2
    AST_RUN_NEEDS_EDGE: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $fell(clk_stopped) |-> $past(seen_edge))
        else $error("monitor released without a toggle"); // R3

endmodule

// File: rtl/hold_sync.sv
module hold_sync
    import clkstop_fifo_pkg::*;
#(
    parameter int unsigned STAGES = DEF_SYNC
) (
    input  logic clk,
    input  logic hold_req,
    output logic hold_out
);
    // Enters hold at once, leaves it only after STAGES edges of clk
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[STAGES-2:0], 1'b0};

    always_ff @(posedge clk or posedge hold_req) begin
        if (hold_req) sh_q <= '1;
        else          sh_q <= sh_d;
    end

    assign hold_out = sh_q[STAGES-1];

endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
    import clkstop_fifo_pkg::*;
#(
    parameter  int unsigned DEPTH = DEF_DEPTH,
    parameter  int unsigned SYNC  = DEF_SYNC,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_hold,
    input  logic          wr_en,
    input  logic [PW-1:0] rd_gray_async,
    output logic [PW-1:0] wr_gray,
    output logic [AW-1:0] wr_addr,
    output logic          wr_accept,
    output logic          wr_overflow
);
    localparam logic [PW-1:0] PRESET_BIN  = PW'(DEPTH / 2);
    localparam logic [PW-1:0] PRESET_GRAY = PRESET_BIN ^ (PRESET_BIN >> 1);

    typedef struct packed {
        logic [PW-1:0]           bin;
        logic [PW-1:0]           gray;
        logic [SYNC-1:0][PW-1:0] rsync;
        logic                    ovf;
    } wr_t;

    localparam wr_t WR_RESET = '{bin: PRESET_BIN, gray: PRESET_GRAY, rsync: '0, ovf: 1'b0};

    wr_t  w_d, w_q;
    logic full;
    logic [PW-1:0] rd_seen_bin;
    logic [PW-1:0] wr_level;

    always_comb begin
        full      = (w_q.gray == {~w_q.rsync[SYNC-1][PW-1:PW-2], w_q.rsync[SYNC-1][PW-3:0]});
        wr_accept = wr_en & ~full & ~wr_hold;

        w_d       = w_q;
        w_d.bin   = w_q.bin + PW'(wr_accept);
        w_d.gray  = w_d.bin ^ (w_d.bin >> 1);
        w_d.rsync = {w_q.rsync[SYNC-2:0], rd_gray_async};
        w_d.ovf   = w_q.ovf | (wr_en & full & ~wr_hold);
    end

    always_ff @(posedge wr_clk or posedge wr_hold) begin
        if (wr_hold) w_q <= WR_RESET;
        else         w_q <= w_d;
    end

    assign wr_gray     = w_q.gray;
    assign wr_addr     = w_q.bin[AW-1:0];
    assign wr_overflow = w_q.ovf;

    // Occupancy as the write side believes it
    always_comb begin
        rd_seen_bin[PW-1] = w_q.rsync[SYNC-1][PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rd_seen_bin[i] = rd_seen_bin[i+1] ^ w_q.rsync[SYNC-1][i];
        end
        wr_level = w_q.bin - rd_seen_bin;
    end

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_hold)
        wr_level <= PW'(DEPTH))
        else $error("write pointer lapped the read pointer"); // R6
    AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (wr_hold)
        $onehot0(wr_gray ^ $past(wr_gray)))
        else $error("write gray pointer moved more than one bit"); // R5

endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import clkstop_fifo_pkg::*;
#(
    parameter  int unsigned DEPTH = DEF_DEPTH,
    parameter  int unsigned WIDTH = DEF_WIDTH,
    parameter  int unsigned SYNC  = DEF_SYNC,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1
) (
    input  logic             rd_clk,
    input  logic             rd_hold,
    input  logic             rd_en,
    input  logic [PW-1:0]    wr_gray_async,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic [PW-1:0]    rd_gray,
    output logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_underflow
);
    localparam logic [PW-1:0] PRESET_BIN  = PW'(DEPTH / 2);
    localparam logic [PW-1:0] PRESET_GRAY = PRESET_BIN ^ (PRESET_BIN >> 1);

    typedef struct packed {
        logic [PW-1:0]           bin;
        logic [PW-1:0]           gray;
        logic [SYNC-1:0][PW-1:0] wsync;
        logic [WIDTH-1:0]        data;
        logic                    unf;
    } rd_t;

    localparam rd_t RD_RESET = '{bin: '0, gray: '0, wsync: {SYNC{PRESET_GRAY}},
                                 data: '0, unf: 1'b0};

    rd_t  r_d, r_q;
    logic empty;
    logic accept;
    logic [PW-1:0] wr_seen_bin;
    logic [PW-1:0] rd_level;

    always_comb begin
        empty  = (r_q.gray == r_q.wsync[SYNC-1]);
        accept = rd_en & ~empty & ~rd_hold;

        r_d       = r_q;
        r_d.bin   = r_q.bin + PW'(accept);
        r_d.gray  = r_d.bin ^ (r_d.bin >> 1);
        r_d.wsync = {r_q.wsync[SYNC-2:0], wr_gray_async};
        r_d.data  = accept ? mem_rdata : r_q.data;
        r_d.unf   = r_q.unf | (rd_en & empty & ~rd_hold);
    end

    always_ff @(posedge rd_clk or posedge rd_hold) begin
        if (rd_hold) r_q <= RD_RESET;
        else         r_q <= r_d;
    end

    assign rd_gray      = r_q.gray;
    assign rd_addr      = r_q.bin[AW-1:0];
    assign rd_data      = r_q.data;
    assign rd_underflow = r_q.unf;

    // Occupancy as the read side believes it
    always_comb begin
        wr_seen_bin[PW-1] = r_q.wsync[SYNC-1][PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wr_seen_bin[i] = wr_seen_bin[i+1] ^ r_q.wsync[SYNC-1][i];
        end
        rd_level = wr_seen_bin - r_q.bin;
    end

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rd_hold)
        rd_level <= PW'(DEPTH))
        else $error("read pointer passed the write pointer"); // R7
    AST_HOLD_ON_EMPTY: assert property (@(posedge rd_clk) disable iff (rd_hold)
        (rd_en && empty) |=> $stable(rd_data))
        else $error("read from empty buffer changed the output"); // R7
    AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (rd_hold)
        $onehot0(rd_gray ^ $past(rd_gray)))
        else $error("read gray pointer moved more than one bit"); // R5

endmodule

// File: rtl/clkstop_elastic_fifo.sv
module clkstop_elastic_fifo
    import clkstop_fifo_pkg::*;
#(
    parameter  int unsigned DEPTH     = DEF_DEPTH,
    parameter  int unsigned WIDTH     = DEF_WIDTH,
    parameter  int unsigned STOP_CYC  = DEF_STOP_CYC,
    parameter  int unsigned RUN_EDGES = DEF_RUN_EDGES,
    parameter  int unsigned SYNC      = DEF_SYNC,
    localparam int unsigned AW        = $clog2(DEPTH),
    localparam int unsigned PW        = AW + 1
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             wr_clk,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_held,
    output logic             wr_overflow,
    input  logic             rd_clk,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_held,
    output logic             rd_underflow
);
    localparam int unsigned NDOM = 2;

    logic            bus_stopped;
    logic [NDOM-1:0] dom_clk;
    logic [NDOM-1:0] dom_hold;
    logic [PW-1:0]   wr_gray, rd_gray;
    logic [AW-1:0]   wr_addr, rd_addr;
    logic            wr_accept;
    logic [WIDTH-1:0] mem_rdata;
    logic [WIDTH-1:0] mem_q [DEPTH];

    clk_activity_mon #(
        .STOP_CYC  (STOP_CYC),
        .RUN_EDGES (RUN_EDGES),
        .SYNC      (SYNC)
    ) u_mon (
        .ref_clk     (ref_clk),
        .ref_rst_n   (ref_rst_n),
        .mon_clk     (wr_clk),
        .clk_stopped (bus_stopped)
    );

    // One release synchroniser per clock domain: index 0 write, index 1 read
    assign dom_clk = {rd_clk, wr_clk};

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        hold_sync #(.STAGES(SYNC)) u_hold (
            .clk      (dom_clk[d]),
            .hold_req (bus_stopped),
            .hold_out (dom_hold[d])
        );
    end

    assign wr_held = dom_hold[0];
    assign rd_held = dom_hold[1];

    fifo_wr_ctl #(
        .DEPTH (DEPTH),
        .SYNC  (SYNC)
    ) u_wr (
        .wr_clk        (wr_clk),
        .wr_hold       (wr_held),
        .wr_en         (wr_en),
        .rd_gray_async (rd_gray),
        .wr_gray       (wr_gray),
        .wr_addr       (wr_addr),
        .wr_accept     (wr_accept),
        .wr_overflow   (wr_overflow)
    );

    fifo_rd_ctl #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .SYNC  (SYNC)
    ) u_rd (
        .rd_clk        (rd_clk),
        .rd_hold       (rd_held),
        .rd_en         (rd_en),
        .wr_gray_async (wr_gray),
        .mem_rdata     (mem_rdata),
        .rd_gray       (rd_gray),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .rd_underflow  (rd_underflow)
    );

    // Storage: written on the bus clock, read combinationally by the link side
    always_ff @(posedge wr_clk) begin
        if (wr_accept) mem_q[wr_addr] <= wr_data;
    end

    assign mem_rdata = mem_q[rd_addr];

endmodule

// File: tb/test_clkstop_elastic_fifo.sv
`timescale 1ns/1ps
module test_clkstop_elastic_fifo;
    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;
    localparam int WIDTH = 10;

    logic ref_clk = 1'b0;
    logic ref_rst_n = 1'b1;
    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic wr_run = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic wr_held, rd_held, wr_overflow, rd_underflow;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    int model_q[$];

    clkstop_elastic_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_clkstop_elastic_fifo (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
        .wr_held(wr_held), .wr_overflow(wr_overflow),
        .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data),
        .rd_held(rd_held), .rd_underflow(rd_underflow)
    );

    always #5 ref_clk = ~ref_clk;          // 100 MHz reference
    always #17 rd_clk = ~rd_clk;
    always begin
        #15;
        if (wr_run) wr_clk = ~wr_clk;
    end

    function automatic bit is_ok(int act, int exp);
        return act == exp;
    endfunction

    task automatic check_eq(string req, int act, int exp);
        n_chk++;
        if (!is_ok(act, exp)) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic stop_wr(bit level);
        wr_en = 1'b0;
        if (level) @(posedge wr_clk);
        else       @(negedge wr_clk);
        wr_run = 1'b0;
    endtask

    task automatic start_and_release();
        wr_run = 1'b1;
        repeat (2) @(posedge wr_clk);
        #1;
        check_eq("R3 hold kept after two edges (wr)", int'(wr_held), 1);
        check_eq("R3 hold kept after two edges (rd)", int'(rd_held), 1);
        for (int i = 0; i < 400 && (wr_held || rd_held); i++) @(posedge ref_clk);
        #2;
        check_eq("R3 released wr", int'(wr_held), 0);
        check_eq("R3 released rd", int'(rd_held), 0);
        repeat (10) @(posedge rd_clk);
    endtask

    task automatic resync(bit level);
        stop_wr(level);
        repeat (40) @(posedge ref_clk);
        #2;
        check_eq($sformatf("R2 wr held, parked at %0d", level), int'(wr_held), 1);
        check_eq($sformatf("R2 rd held, parked at %0d", level), int'(rd_held), 1);
        check_eq("R8 overflow cleared", int'(wr_overflow), 0);
        check_eq("R8 underflow cleared", int'(rd_underflow), 0);
        start_and_release();
    endtask

    task automatic write_burst(int n, int base);
        @(negedge wr_clk);
        for (int i = 0; i < n; i++) begin
            wr_en = 1'b1;
            wr_data = WIDTH'(base + i * 37);
            @(negedge wr_clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic read_one(output int val);
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        val = int'(rd_data);
    endtask

    initial begin
        int v;
        int prev;
        void'($urandom(32'h5EED));
        #2 ref_rst_n = 1'b0;
        repeat (3) @(posedge ref_clk);
        ref_rst_n = 1'b1;
        repeat (30) @(posedge ref_clk);
        #2;
        // R1 reset state while the bus clock has never run
        check_eq("R1 wr held", int'(wr_held), 1);
        check_eq("R1 rd held", int'(rd_held), 1);
        check_eq("R1 overflow", int'(wr_overflow), 0);
        check_eq("R1 underflow", int'(rd_underflow), 0);
        check_eq("R1 rd_data", int'(rd_data), 0);

        start_and_release();

        // R4: HALF reads succeed with no writes
        for (int i = 0; i < HALF; i++) read_one(v);
        check_eq("R4 half reads without underflow", int'(rd_underflow), 0);
        prev = int'(rd_data);
        read_one(v);
        check_eq("R7 underflow set", int'(rd_underflow), 1);
        check_eq("R7 data unchanged", v, prev);

        // R9: one word, result right after the accepting edge
        write_burst(1, 677);
        repeat (8) @(posedge rd_clk);
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(posedge rd_clk);
        #1;
        check_eq("R9 data after accepting edge", int'(rd_data), 677);
        @(negedge rd_clk);
        rd_en = 1'b0;
        check_eq("R7 underflow sticky", int'(rd_underflow), 1);

        // R4 / R6: capacity from release, then overflow
        resync(1'b1);
        write_burst(HALF, 100);
        check_eq("R4 half writes without overflow", int'(wr_overflow), 0);
        write_burst(1, 999);
        check_eq("R6 overflow set", int'(wr_overflow), 1);
        repeat (8) @(posedge rd_clk);
        @(negedge rd_clk);
        rd_en = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge rd_clk);
            if (i >= HALF)
                check_eq("R6 stored word intact", int'(rd_data), (100 + (i - HALF) * 37) % 1024);
        end
        rd_en = 1'b0;
        prev = int'(rd_data);
        read_one(v);
        check_eq("R6 dropped word not stored", v, prev);
        check_eq("R6 underflow after draining", int'(rd_underflow), 1);
        check_eq("R6 overflow sticky", int'(wr_overflow), 1);

        // R5: random concurrent traffic after a low-level park (R8 checked inside)
        resync(1'b0);
        model_q.delete();
        for (int i = 0; i < HALF; i++) model_q.push_back(-1);
        fork
            begin
                for (int i = 0; i < 600; i++) begin
                    @(negedge wr_clk);
                    if (model_q.size() <= DEPTH - 6 && $urandom_range(3) != 0) begin
                        wr_en = 1'b1;
                        wr_data = WIDTH'($urandom_range(1023));
                        model_q.push_back(int'(wr_data));
                    end else begin
                        wr_en = 1'b0;
                    end
                end
                @(negedge wr_clk);
                wr_en = 1'b0;
            end
            begin
                bit pend = 1'b0;
                int exp = 0;
                for (int i = 0; i < 700; i++) begin
                    @(negedge rd_clk);
                    if (pend && exp >= 0) check_eq("R5 stream word", int'(rd_data), exp);
                    if (model_q.size() >= 6 && $urandom_range(3) != 0) begin
                        rd_en = 1'b1;
                        exp = model_q.pop_front();
                        pend = 1'b1;
                    end else begin
                        rd_en = 1'b0;
                        pend = 1'b0;
                    end
                end
                @(negedge rd_clk);
                if (pend && exp >= 0) check_eq("R5 stream word", int'(rd_data), exp);
                rd_en = 1'b0;
            end
        join
        check_eq("R5 no overflow in stream", int'(wr_overflow), 0);
        check_eq("R5 no underflow in stream", int'(rd_underflow), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #200_000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule